// File: doc/BRIEF.md
# Two-Sink Port Switch Control Slave

This block is the control-plane front end of a two-sink-port video switch. It sits on a two-wire serial bus (I2C) as a slave. It holds one control byte for each sink port and one byte for the source plug-in status. It turns the two port bytes into per-port control lines: a de-emphasis enable, a side-channel buffer enable, and an active-low enable for the high-speed data path.

The slave address is seven bits wide. The upper five bits are fixed at 5'b10110. The two lowest bits come straight from two strap pins, which are compared live at every address phase and never latched. Up to four of these slaves can therefore share one bus, and a board can move a device to another address at run time. A write carries the slave address, one sub-address byte and exactly one data byte. A read returns one byte from the sub-address selected last. The block samples SCL and SDA on its own system clock and drives SDA only as an open-drain pull-down.

Top module: `pswitch_ctrl`

## Requirements
- R1: After reset all three registers hold 8'h03. Every de-emphasis and side-channel output is 0, every active-low path enable is 0 (path on), and SDA is released.
- R2: The slave acknowledges an address byte whose upper seven bits equal {5'b10110, A1, A0}, with A1 as bit 1 and A0 as bit 0. Any other address is not acknowledged, and the rest of that transaction changes no register and no pointer.
- R3: The two address pins are compared at every address phase. After the pins change, the old address is not acknowledged and the new one is.
- R4: In a write, the address, the sub-address and the data byte are each acknowledged by pulling SDA low in the ninth clock. The data byte is stored at the sub-address when that sub-address is 0x01, 0x02 or 0x03.
- R5: In a read (address LSB = 1), the slave shifts out the byte at the last selected sub-address, MSB first, one bit per SCL low phase. It then releases SDA, whatever the master answers, until the next START or STOP.
- R6: A write to sub-address 0x00 or to 0x04..0xFF is acknowledged and discarded. A read at such a sub-address returns 8'h00.
- R7: For sink port p (p = 1 at sub-address 0x01, p = 2 at 0x02): de-emphasis enable = bit 4, side-channel buffer enable = bit 3, active-low path enable = bit 2. Writing 0x03 changes none of these outputs.
- R8: A write stores only one data byte. Any further byte in the same transaction is not acknowledged and stores nothing, including at the next sub-address.
- R9: A START (SDA falls while SCL is high) restarts the address phase from any state, and a STOP (SDA rises while SCL is high) returns the slave to idle. A write cut off before its data byte is complete stores nothing, but the sub-address it sent stays selected.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins | input | 2 | Live low address bits: [1] is A1, [0] is A0 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| deemph | output | NUM_PORTS | De-emphasis enable per sink port, bit 0 = port 1 |
| side_en | output | NUM_PORTS | Side-channel buffer enable per sink port |
| path_en_n | output | NUM_PORTS | Active-low data-path enable per sink port |

## Verification
The bound checker watches, on every cycle, the invariants that need no stimulus to be meaningful:
- SDA drive changes only after a synchronized SCL fall or a bus condition.
- Decoded outputs move only in the cycle after a one-cycle write strobe aimed at a sink-port register.
- At most one write occurs between bus conditions.
- The outputs show their reset values when reset is released.

The bench covers the behaviours that only complete bus transactions can show:
- address matching against pins that change between transactions;
- acknowledgement patterns for the address, sub-address and data bytes;
- read-back of the selected byte;
- discarding of undefined sub-addresses and of surplus bytes;
- aborts by repeated START.

// File: rtl/pswitch_pkg.sv
package pswitch_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [4:0]  DEV_FIXED  = 5'b10110;
    localparam logic [7:0]  REG_RESET  = 8'h03;
    localparam int          BIT_DEEMPH = 4;
    localparam int          BIT_SIDE   = 3;
    localparam int          BIT_PATHN  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_ACK,
        ST_READ,
        ST_IGNORE
    } bus_state_e;

    typedef struct packed {
        logic deemph;
        logic side_en;
        logic path_en_n;
    } port_ctl_t;

    function automatic port_ctl_t decode_port(input logic [BYTE_W-1:0] r);
        port_ctl_t c;
        c.deemph    = r[BIT_DEEMPH];
        c.side_en   = r[BIT_SIDE];
        c.path_en_n = r[BIT_PATHN];
        return c;
    endfunction

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] pins);
        return a == {DEV_FIXED, pins};
    endfunction

endpackage

// File: rtl/pswitch_line_sync.sv
module pswitch_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] scl_p, sda_p;
    logic         scl_d, sda_d, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[MSB-1:0], scl_i};
            sda_p <= {sda_p[MSB-1:0], sda_i};
            scl_d <= scl_p[MSB];
            sda_d <= sda_p[MSB];
        end
    end

    assign scl_s     = scl_p[MSB];
    assign sda_s     = sda_p[MSB];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/pswitch_xfer_fsm.sv
module pswitch_xfer_fsm
    import pswitch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_pins,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] wr_data
);
    bus_state_e        state, after;
    logic [BYTE_W-1:0] rx, tx;
    logic [3:0]        cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            after   <= ST_IDLE;
            rx      <= '0;
            tx      <= '0;
            cnt     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            ptr     <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_DATA: begin
                        if (scl_rise && cnt < 4'd8) begin
                            rx  <= {rx[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(rx[7:1], addr_pins)) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    after  <= rx[0] ? ST_READ : ST_SUB;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end else if (state == ST_SUB) begin
                                ptr    <= rx;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                after  <= ST_DATA;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= rx;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                                after   <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (after == ST_READ) begin
                                tx     <= {rd_data[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~rd_data[BYTE_W-1];
                                cnt    <= 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                            end
                            state <= after;
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_IGNORE;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-1];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pswitch_regs.sv
module pswitch_regs
    import pswitch_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wr_ptr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [BYTE_W-1:0]    rd_ptr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NUM_PORTS-1:0] deemph,
    output logic [NUM_PORTS-1:0] side_en,
    output logic [NUM_PORTS-1:0] path_en_n
);
    localparam int NREG = NUM_PORTS + 1;

    logic [BYTE_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= REG_RESET;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++)
                if (wr_ptr == BYTE_W'(i + 1)) regs[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_ptr == BYTE_W'(i + 1)) rd_data = regs[i];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_ctl_t ctl;
        assign ctl          = decode_port(regs[p]);
        assign deemph[p]    = ctl.deemph;
        assign side_en[p]   = ctl.side_en;
        assign path_en_n[p] = ctl.path_en_n;
    end

endmodule

// File: rtl/pswitch_ctrl.sv
module pswitch_ctrl
    import pswitch_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [1:0]           addr_pins,
    output logic                 sda_oe,
    output logic [NUM_PORTS-1:0] deemph,
    output logic [NUM_PORTS-1:0] side_en,
    output logic [NUM_PORTS-1:0] path_en_n
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] ptr, wr_data, rd_data;

    pswitch_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pswitch_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pins (addr_pins),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .ptr       (ptr),
        .wr_data   (wr_data)
    );

    pswitch_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_ptr    (ptr),
        .wr_data   (wr_data),
        .rd_ptr    (ptr),
        .rd_data   (rd_data),
        .deemph    (deemph),
        .side_en   (side_en),
        .path_en_n (path_en_n)
    );

endmodule

// File: rtl/pswitch_ctrl_chk.sv
module pswitch_ctrl_chk #(
    parameter int NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sda_oe,
    input logic                 scl_fall,
    input logic                 start_det,
    input logic                 stop_det,
    input logic                 wr_en,
    input logic [7:0]           wr_ptr,
    input logic [NUM_PORTS-1:0] deemph,
    input logic [NUM_PORTS-1:0] side_en,
    input logic [NUM_PORTS-1:0] path_en_n
);
    logic wr_seen;

    always_ff @(posedge clk) begin
        if (rst || start_det || stop_det) wr_seen <= 1'b0;
        else if (wr_en)                   wr_seen <= 1'b1;
    end

    assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (deemph == '0 && side_en == '0 && path_en_n == '0 && !sda_oe));

    assert_sda_edge_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    assert_out_on_port_write_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable({deemph, side_en, path_en_n}) |->
            ($past(wr_en) && $past(wr_ptr) >= 8'd1 && $past(wr_ptr) <= 8'(NUM_PORTS)));

    assert_one_write_per_txn_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !wr_seen);

    assert_write_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

endmodule

bind pswitch_ctrl pswitch_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .wr_ptr    (ptr),
    .deemph    (deemph),
    .side_en   (side_en),
    .path_en_n (path_en_n)
);

// File: tb/sim_pswitch_ctrl.sv
`timescale 1ns/1ps
module sim_pswitch_ctrl;
    localparam int H = 8;
    localparam logic [4:0] FIX = 5'b10110;

    logic       clk = 1'b0, rst = 1'b1, scl = 1'b1, m_low = 1'b0;
    logic [1:0] pins = 2'b00;
    logic       sda_oe, sda_line;
    logic [1:0] deemph, side_en, path_en_n;

    assign sda_line = !(m_low || sda_oe);
    always #10 clk = ~clk;

    pswitch_ctrl u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .addr_pins(pins),
        .sda_oe(sda_oe), .deemph(deemph), .side_en(side_en), .path_en_n(path_en_n)
    );

    logic [7:0] mreg [1:3];
    int n_chk = 0, n_bad = 0, viol = 0;
    bit finished = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    // R10 monitor: slave drive must not move while SCL held high
    always @(negedge clk) begin
        if (!rst && scl && prev_scl && sda_oe != prev_oe) viol++;
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] p);
        return (p >= 8'd1 && p <= 8'd3) ? mreg[p[1:0]] : 8'h00;
    endfunction

    function automatic logic [5:0] exp_out();
        return {mreg[2][4], mreg[1][4], mreg[2][3], mreg[1][3], mreg[2][2], mreg[1][2]};
    endfunction

    task automatic bus_start();
        m_low = 0; tick(H); scl = 1; tick(H); m_low = 1; tick(H); scl = 0; tick(H);
    endtask

    task automatic bus_stop();
        m_low = 1; tick(H); scl = 1; tick(H); m_low = 0; tick(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; tick(H); scl = 1; tick(H); scl = 0;
        end
        m_low = 0; tick(H); scl = 1; tick(H/2); ack = sda_line; tick(H/2); scl = 0;
    endtask

    task automatic get_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_low = 0; tick(H); scl = 1; tick(H/2); b[i] = sda_line; tick(H/2); scl = 0;
        end
        m_low = 0; tick(H); scl = 1; tick(H); scl = 0;   // master NACK
    endtask

    task automatic check_outputs(input string tag);
        tick(4);
        chk({deemph, side_en, path_en_n}, exp_out(), tag);
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] sub, input logic [7:0] d);
        logic a;
        bit hit = (dev == {FIX, pins});
        bus_start();
        put_byte({dev, 1'b0}, a);
        chk(a, hit ? 0 : 1, "R2 address ack");
        if (hit) begin
            put_byte(sub, a);  chk(a, 0, "R4 sub ack");
            put_byte(d, a);    chk(a, 0, "R4/R6 data ack");
            if (sub >= 8'd1 && sub <= 8'd3) mreg[sub[1:0]] = d;
        end
        bus_stop();
        check_outputs("R7 decode");
    endtask

    task automatic rd_txn(input logic [7:0] sub, input string tag);
        logic a; logic [7:0] d;
        bus_start();
        put_byte({FIX, pins, 1'b0}, a); chk(a, 0, "R2 address ack");
        put_byte(sub, a);               chk(a, 0, "R4 sub ack");
        bus_start();
        put_byte({FIX, pins, 1'b1}, a); chk(a, 0, "R5 read address ack");
        get_byte(d);
        chk(d, exp_read(sub), tag);
        tick(H);
        chk(sda_oe, 0, "R5 released after byte");
        bus_stop();
    endtask

    initial begin
        logic a; logic [7:0] d;
        void'($urandom(32'd4711));
        for (int i = 1; i <= 3; i++) mreg[i] = 8'h03;
        tick(5); rst = 0; tick(3);
        chk({deemph, side_en, path_en_n, sda_oe}, 7'b0, "R1 reset outputs");
        for (int s = 1; s <= 3; s++) rd_txn(8'(s), "R1 reset value");

        // R7 directed decode of each field per port
        wr_txn({FIX, pins}, 8'h01, 8'h10);
        wr_txn({FIX, pins}, 8'h02, 8'h08);
        wr_txn({FIX, pins}, 8'h01, 8'h04);
        wr_txn({FIX, pins}, 8'h03, 8'hFF);
        rd_txn(8'h03, "R4 status readback");

        // R6 undefined sub-addresses
        wr_txn({FIX, pins}, 8'h00, 8'hAA);
        wr_txn({FIX, pins}, 8'h04, 8'h55);
        rd_txn(8'h00, "R6 read undefined");
        rd_txn(8'hFF, "R6 read undefined");

        // R3 live address pins
        pins = 2'b01;
        wr_txn({FIX, 2'b01}, 8'h02, 8'h1C);
        pins = 2'b10;
        wr_txn({FIX, 2'b01}, 8'h02, 8'h00);
        chk({deemph, side_en, path_en_n}, exp_out(), "R3 old address ignored");
        wr_txn({FIX, 2'b10}, 8'h02, 8'h14);
        rd_txn(8'h02, "R3 new address readback");

        // R8 surplus bytes
        bus_start();
        put_byte({FIX, pins, 1'b0}, a);
        put_byte(8'h01, a);
        put_byte(8'h18, a); chk(a, 0, "R8 first data ack"); mreg[1] = 8'h18;
        put_byte(8'hE7, a); chk(a, 1, "R8 surplus byte nack");
        bus_stop();
        check_outputs("R8 outputs");
        rd_txn(8'h02, "R8 next register untouched");
        rd_txn(8'h01, "R8 first byte kept");

        // R9 repeated START aborts write, pointer kept
        bus_start();
        put_byte({FIX, pins, 1'b0}, a);
        put_byte(8'h02, a);
        for (int i = 0; i < 4; i++) begin
            m_low = 1'b0; tick(H); scl = 1; tick(H); scl = 0;
        end
        bus_start();
        put_byte({FIX, pins, 1'b1}, a); chk(a, 0, "R9 restart address ack");
        get_byte(d);
        chk(d, mreg[2], "R9 aborted write left data");
        bus_stop();
        check_outputs("R9 outputs");

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int op = $urandom % 4;
            pins = 2'($urandom);
            case (op)
                0: wr_txn({FIX, pins}, 8'(1 + $urandom % 3), 8'($urandom));
                1: wr_txn({FIX, pins}, 8'($urandom % 6), 8'($urandom));
                2: rd_txn(8'($urandom % 5), "R5 random read");
                default: begin
                    logic [6:0] bad = {FIX, pins} ^ 7'(1 + $urandom % 127);
                    wr_txn(bad, 8'h01, 8'($urandom));
                end
            endcase
        end

        chk(viol, 0, "R10 drive stable while SCL high");
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule